// File: doc/BRIEF.md
# Single-Line Non-Maskable Interrupt Controller

This block watches one external interrupt pin, which may change at any time relative to the block's clock. It turns the condition picked by a two-bit trigger field into a sticky pending flag. When the source is unmasked, it raises one registered interrupt request toward the parent interrupt controller. The trigger condition is one of two levels or one of two edges.

Software reaches the block through a single-cycle register port. There are three words: a control word that holds the trigger field and free storage bits, a pending word, and an enable word. The control word is always at offset 0x00. The offsets of the pending and enable words come from an elaboration-time layout parameter, so one design can serve three existing register maps. The pending flag is cleared by writing one to bit 0 of the pending word.

The pending flag is held in a two-state machine. `PEND_IDLE` moves to `PEND_SET` when the trigger condition is seen (transition *raise*). `PEND_SET` returns to `PEND_IDLE` only on a clear write that falls in a cycle with no trigger hit (transition *ack*). In every other case the machine stays where it is (transitions *hold_idle* and *hold_set*).

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset the control word reads 0 (trigger field 0, active-low level), and the pending word and the enable word both read 0. The synchroniser stages reset to the high level, so a high pin does not look like an event. `irq_out` is 0.
- R2: The trigger field is bits [1:0] of the control word. Its codes are 0 for an active-low level, 1 for a falling edge, 2 for an active-high level and 3 for a rising edge. In the level codes, pending is set in every cycle that the synchronised pin sits at the active level.
- R3: In the edge codes, pending is set when the synchronised sample makes the selected transition against the previous sample. Pending then stays set until it is cleared, even after the pin returns.
- R4: Writing 1 to bit 0 of the pending word clears the flag. Writing 0 leaves it unchanged.
- R5: If a trigger hit and a clear write fall in the same cycle, pending stays set.
- R6: In a level code, a clear has no lasting effect while the pin stays at the active level. Pending reads 1 again right afterwards.
- R7: Bit 0 of the enable word masks the source when 0 and unmasks it when 1. Pending is still set while the source is masked.
- R8: `irq_out` equals pending AND enable, delayed by one register stage.
- R9: The layout parameter sets the offsets. Layout 0 has pending at 0x04 and enable at 0x34. Layout 1 (the default) has pending at 0x04 and enable at 0x08. Layout 2 has enable at 0x04 and pending at 0x08.
- R10: Control bits above [1:0] are plain read/write storage and read back as written.
- R11: A read of any unmapped offset returns 0. A write to an unmapped offset changes nothing.
- R12: The pin passes through two synchroniser flops. A pin change driven before clock edge 1 is visible in the pending word after edge 3 and in `irq_out` after edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pin | input | 1 | Asynchronous external interrupt pin |
| reg_addr | input | ADDR_W (8) | Byte offset of the register word |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, same cycle |
| irq_out | output | 1 | Registered interrupt request to the parent controller |

## Verification
A pin change driven at a falling clock edge reaches the second synchroniser flop at the second rising edge. It shows in the pending word after the third rising edge and on `irq_out` after the fourth. The bench therefore waits at least five cycles before it samples a pin-driven result. In the latency and coincidence tests it counts edges one at a time. A write lands at the rising edge that follows the falling edge where it was driven. Its effect on a register read is checked at the next falling edge, and its effect on `irq_out` one cycle later. All samples and all drives happen at falling edges, away from the edge that updates the design.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_LO    = 2'd0,
        TRIG_EDGE_FALL = 2'd1,
        TRIG_LVL_HI    = 2'd2,
        TRIG_EDGE_RISE = 2'd3
    } trig_mode_e;

    typedef enum logic {
        PEND_IDLE = 1'b0,
        PEND_SET  = 1'b1
    } pend_state_e;

    localparam int LAYOUT_A = 0;
    localparam int LAYOUT_B = 1;
    localparam int LAYOUT_C = 2;

    localparam int CTRL_OFFSET = 'h00;

    function automatic int pend_offset(input int layout);
        return (layout == LAYOUT_C) ? 'h08 : 'h04;
    endfunction

    function automatic int enable_offset(input int layout);
        int off;
        case (layout)
            LAYOUT_A: off = 'h34;
            LAYOUT_C: off = 'h04;
            default:  off = 'h08;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/nmi_line_sync.sv
module nmi_line_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic cur,
    output logic prev
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE_LVL}};
            prev_q  <= IDLE_LVL;
        end else begin
            chain_q <= {chain_q[LAST-1:0], pin};
            prev_q  <= chain_q[LAST];
        end
    end

    assign cur  = chain_q[LAST];
    assign prev = prev_q;
endmodule

// File: rtl/nmi_line_detect.sv
module nmi_line_detect
    import nmi_line_pkg::*;
(
    input  trig_mode_e mode,
    input  logic       cur,
    input  logic       prev,
    output logic       hit
);
    always_comb begin
        hit = 1'b0;
        unique case (mode)
            TRIG_LVL_LO:    hit = ~cur;
            TRIG_EDGE_FALL: hit = prev & ~cur;
            TRIG_LVL_HI:    hit = cur;
            TRIG_EDGE_RISE: hit = cur & ~prev;
        endcase
    end
endmodule

// File: rtl/nmi_line_fsm.sv
module nmi_line_fsm
    import nmi_line_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    input  logic en,
    output logic pend,
    output logic irq
);
    pend_state_e state_q, state_d;
    logic        irq_q;

    // next state: raise / ack / hold_idle / hold_set
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE: if (hit)         state_d = PEND_SET;
            PEND_SET:  if (clr && !hit) state_d = PEND_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PEND_IDLE;
        else        state_q <= state_d;
    end

    // registered output stage
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (state_q == PEND_SET) && en;
    end

    assign pend = (state_q == PEND_SET);
    assign irq  = irq_q;
endmodule

// File: rtl/nmi_line_regs.sv
module nmi_line_regs
    import nmi_line_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LAYOUT = LAYOUT_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pend,
    output trig_mode_e        mode,
    output logic              en,
    output logic              clr
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFFSET);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(pend_offset(LAYOUT));
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(enable_offset(LAYOUT));

    logic [DATA_W-1:0] ctrl_q;
    logic              en_q;
    logic              sel_ctrl, sel_pend, sel_en;

    assign sel_ctrl = (addr == A_CTRL);
    assign sel_pend = (addr == A_PEND);
    assign sel_en   = (addr == A_EN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            en_q   <= 1'b0;
        end else if (we) begin
            if (sel_ctrl) ctrl_q <= wdata;
            if (sel_en)   en_q   <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ctrl)      rdata    = ctrl_q;
        else if (sel_pend) rdata[0] = pend;
        else if (sel_en)   rdata[0] = en_q;
    end

    assign clr  = we && sel_pend && wdata[0];
    assign mode = trig_mode_e'(ctrl_q[1:0]);
    assign en   = en_q;
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
    import nmi_line_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int LAYOUT      = LAYOUT_B,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    trig_mode_e trig_mode;
    logic       smp_cur, smp_prev;
    logic       trig_hit, clr_req, en_bit, pend_flag;

    nmi_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(nmi_pin), .cur(smp_cur), .prev(smp_prev)
    );

    nmi_line_detect u_detect (
        .mode(trig_mode), .cur(smp_cur), .prev(smp_prev), .hit(trig_hit)
    );

    nmi_line_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(LAYOUT)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
        .rdata(reg_rdata), .pend(pend_flag), .mode(trig_mode), .en(en_bit), .clr(clr_req)
    );

    nmi_line_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(trig_hit), .clr(clr_req), .en(en_bit),
        .pend(pend_flag), .irq(irq_out)
    );
endmodule

// File: rtl/nmi_line_chk.sv
module nmi_line_chk (
    input logic clk,
    input logic rst_n,
    input logic pend,
    input logic en,
    input logic hit,
    input logic clr,
    input logic irq_out
);
    AST_RAISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(pend) |-> $past(hit)); // R2
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (pend && !clr) |=> pend); // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (clr && !hit) |=> !pend); // R4
    AST_HIT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n) (hit && clr) |=> pend); // R5
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !irq_out); // R7
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (pend && en) |=> irq_out); // R8
endmodule

bind nmi_line_ctrl nmi_line_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pend(pend_flag), .en(en_bit),
    .hit(trig_hit), .clr(clr_req), .irq_out(irq_out)
);

// File: tb/sim_nmi_line_ctrl.sv
module sim_nmi_line_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 9;
    // vector fields: [6:5] mode, [4] enable, [3] pin before, [2] pin after, [1] exp pending, [0] exp irq
    localparam logic [6:0] VECS [0:NVEC-1] = '{
        7'b00_1_1_0_1_1,
        7'b00_1_1_1_0_0,
        7'b01_1_1_0_1_1,
        7'b01_1_0_1_0_0,
        7'b10_0_0_1_1_0,
        7'b10_1_0_0_0_0,
        7'b11_1_0_1_1_1,
        7'b11_1_1_0_0_0,
        7'b11_0_0_1_1_0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b1;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_b, rd_a, rd_c;
    logic        irq_b, irq_a, irq_c;
    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] v0, va, vc;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmi_line_ctrl #(.LAYOUT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .nmi_pin(pin), .reg_addr(addr), .reg_we(we),
        .reg_wdata(wdata), .reg_rdata(rd_b), .irq_out(irq_b));
    nmi_line_ctrl #(.LAYOUT(0)) u_a (
        .clk(clk), .rst_n(rst_n), .nmi_pin(pin), .reg_addr(addr), .reg_we(we),
        .reg_wdata(wdata), .reg_rdata(rd_a), .irq_out(irq_a));
    nmi_line_ctrl #(.LAYOUT(2)) u_c (
        .clk(clk), .rst_n(rst_n), .nmi_pin(pin), .reg_addr(addr), .reg_we(we),
        .reg_wdata(wdata), .reg_rdata(rd_c), .irq_out(irq_c));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        addr = a;
        #1;
        v0 = rd_b; va = rd_a; vc = rd_c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset values
        rd(8'h00); check("R1 ctrl", v0, 32'h0);
        rd(8'h04); check("R1 pending", v0, 32'h0);
        rd(8'h08); check("R1 enable", v0, 32'h0);
        check("R1 irq_out", {31'b0, irq_b}, 32'h0);

        // table walk: R2 R3 R7 R8
        for (int k = 0; k < NVEC; k++) begin
            wr(8'h00, {30'b0, VECS[k][6:5]});
            wr(8'h08, {31'b0, VECS[k][4]});
            pin = VECS[k][3];
            idle(5);
            wr(8'h04, 32'h1);
            idle(2);
            pin = VECS[k][2];
            idle(5);
            rd(8'h04);
            check($sformatf("R2/R3 vec%0d pending", k), v0, {31'b0, VECS[k][1]});
            check($sformatf("R7/R8 vec%0d irq", k), {31'b0, irq_b}, {31'b0, VECS[k][0]});
        end

        // R10: upper control bits are storage
        wr(8'h00, 32'hABCD_0003);
        rd(8'h00); check("R10 ctrl readback", v0, 32'hABCD_0003);

        // R4: write 0 no effect, write 1 clears (rising mode)
        pin = 1'b0; idle(5);
        wr(8'h04, 32'h1);
        pin = 1'b1; idle(5);
        wr(8'h04, 32'h0);
        rd(8'h04); check("R4 write0 keeps", v0, 32'h1);
        wr(8'h04, 32'h1);
        rd(8'h04); check("R4 write1 clears", v0, 32'h0);

        // R3: sticky after pin returns
        pin = 1'b0; idle(5);
        pin = 1'b1; idle(5);
        pin = 1'b0; idle(5);
        rd(8'h04); check("R3 sticky edge", v0, 32'h1);

        // R5: edge coincident with clear
        wr(8'h04, 32'h1);
        @(negedge clk); pin = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 8'h04; wdata = 32'h1; we = 1'b1;
        @(negedge clk); we = 1'b0;
        rd(8'h04); check("R5 edge beats clear", v0, 32'h1);

        // R6: level mode clear has no lasting effect
        wr(8'h00, 32'h2);
        idle(5);
        wr(8'h04, 32'h1);
        rd(8'h04); check("R6 level reasserts", v0, 32'h1);

        // R7 masked, then R8 registered output
        wr(8'h08, 32'h0);
        idle(2);
        check("R7 masked irq", {31'b0, irq_b}, 32'h0);
        wr(8'h08, 32'h1);
        check("R8 irq one stage late", {31'b0, irq_b}, 32'h0);
        @(negedge clk);
        check("R8 irq after stage", {31'b0, irq_b}, 32'h1);

        // R12: synchroniser latency in rising mode
        wr(8'h00, 32'h3);
        pin = 1'b0; idle(5);
        wr(8'h04, 32'h1);
        addr = 8'h04;
        pin = 1'b1;
        @(negedge clk);
        @(negedge clk); #1 check("R12 pending not before edge 3", rd_b, 32'h0);
        @(negedge clk); #1 check("R12 pending after edge 3", rd_b, 32'h1);
        check("R12 irq not before edge 4", {31'b0, irq_b}, 32'h0);
        @(negedge clk); #1 check("R12 irq after edge 4", {31'b0, irq_b}, 32'h1);

        // R9: layout offsets; R11: unmapped reads
        wr(8'h34, 32'h1);
        rd(8'h34);
        check("R9 layout0 enable at 0x34", va, 32'h1);
        check("R11 unmapped 0x34 in layout1", v0, 32'h0);
        rd(8'h08); check("R11 unmapped 0x08 in layout0", va, 32'h0);
        wr(8'h04, 32'h1);
        rd(8'h04); check("R9 layout2 enable at 0x04", vc, 32'h1);
        rd(8'h10); check("R11 unmapped 0x10", v0, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule